// File: doc/BRIEF.md
# Vectored Interrupt Source Router

This block takes six level-sensitive interrupt events from inside a chip and steers each one onto one of several output interrupt lines. Five vector registers control the steering. Each holds a target server number, a priority, a line-select field and a pending flag. Events 0 and 1 share the first vector register and therefore one output line. Each of events 2 to 5 has a vector register of its own.

The block captures event levels in status bits that software can read back. It keeps a pending flag per vector: the flag is set when the vector's events are active and the vector is not masked. An all-ones priority is the mask. When software writes a vector register, the block sends the new server and priority to a downstream interrupt controller as a one-cycle configuration pulse. A write that selects a line number outside the supported source range raises a one-cycle error pulse instead.

Top module: `vir_top`

## Requirements
- R1: After reset, every vector register reads back with priority 0xFF, server 0, pending 0, and line-select equal to its own index. The indices are 0 for address 0x10 and 1 to 4 for addresses 0x16 to 0x19. All status bits read 0 and all output lines are low.
- R2: One clock edge after an event input changes, its status bit holds the new level. Event 0 is bit 47 and event 1 is bit 46 of the control word at address 0x0E. Events 2, 3, 4 and 5 are bits 36, 35, 34 and 33 of the status word at address 0x15.
- R3: Output line `irqOut[k]` is high while any status bit of a vector whose line-select equals k is set. The mask has no effect on the line. The shared line of events 0 and 1 drops only when both of their status bits are clear.
- R4: When any status bit of a vector changes, that vector's pending flag (bit 24) is set to (vector active AND priority != 0xFF).
- R5: A vector register write replaces only the server (bits 55:40), priority (bits 39:32) and line-select (bits 31:29) fields. The stored pending flag is kept, and all other written bits are ignored.
- R6: A vector register write with priority 0xFF clears the pending flag.
- R7: One cycle after a vector write whose line-select is below 6, `cfgValid` pulses for one cycle. During the pulse `cfgServer` carries the written server shifted right by 2, and `cfgPrio` and `cfgSrc` carry the written priority and line-select.
- R8: A vector write whose line-select is 6 or 7 pulses `cfgErr` instead of `cfgValid`. The register is still updated and routes its events to that line.
- R9: Reads of addresses that are not mapped return all ones. Writes to the control and status words, and to unmapped addresses, change no readable state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evtIn | input | 6 | Event levels, one per source |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 6 | Register word address for reads and writes |
| regWrData | input | 64 | Write data |
| regRdData | output | 64 | Combinational read data for `regAddr` |
| irqOut | output | NUM_LINES (8) | Output interrupt lines |
| cfgValid | output | 1 | Downstream configuration update pulse |
| cfgErr | output | 1 | Invalid line-select write pulse |
| cfgSrc | output | 3 | Line-select of the last configuration update |
| cfgServer | output | 14 | Server field shifted right by 2 |
| cfgPrio | output | 8 | Priority of the last configuration update |

## Verification
The bench builds the block with its default eight output lines. With eight lines, line-select values 6 and 7 stay routable, so the error path of R8 and the event routing on that path can both be observed at the ports. The shared vector is driven through every overlap of events 0 and 1. The pending flag is checked across writes that mask, unmask and leave the mask unchanged, with events held active.

// File: rtl/vir_pkg.sv
package vir_pkg;
  localparam int NUM_EVT   = 6;
  localparam int NUM_VEC   = 5;
  localparam int DATA_W    = 64;
  localparam int ADDR_W    = 6;
  localparam int SRV_W     = 16;
  localparam int PRI_W     = 8;
  localparam int SEL_W     = 3;
  localparam int LINK_W    = 2;
  localparam int SRC_LIMIT = 6;
  localparam int VIDX_W    = $clog2(NUM_VEC);

  localparam int SRV_LSB  = 40;
  localparam int PRI_LSB  = 32;
  localparam int SEL_LSB  = 29;
  localparam int PEND_BIT = 24;
  localparam int CTRL_EVT0_BIT = 47;
  localparam int STAT_EVT2_BIT = 36;

  localparam logic [ADDR_W-1:0] ADDR_CTRL  = 6'h0E;
  localparam logic [ADDR_W-1:0] ADDR_STAT  = 6'h15;
  localparam logic [ADDR_W-1:0] ADDR_VEC0  = 6'h10;
  localparam logic [ADDR_W-1:0] ADDR_VEC1  = 6'h16;

  typedef enum logic [1:0] {RD_NONE, RD_CTRL, RD_STAT, RD_VEC} rdKind_t;

  typedef struct packed {
    logic [NUM_VEC-1:0] vecWr;
    logic               srcBad;
    rdKind_t            rdKind;
    logic [VIDX_W-1:0]  rdVec;
  } strobe_t;

  function automatic logic [ADDR_W-1:0] vecAddr(input int idx);
    if (idx == 0) vecAddr = ADDR_VEC0;
    else          vecAddr = ADDR_VEC1 + ADDR_W'(idx - 1);
  endfunction
endpackage

// File: rtl/vir_ctrl.sv
module vir_ctrl
  import vir_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [SEL_W-1:0]  wrSel,
  output strobe_t           strb
);
  logic [NUM_VEC-1:0] hit;

  genvar gv;
  generate
    for (gv = 0; gv < NUM_VEC; gv++) begin : g_dec
      assign hit[gv] = (regAddr == vecAddr(gv));
    end
  endgenerate

  always_comb begin
    strb.vecWr  = regWrEn ? hit : '0;
    strb.srcBad = (int'(wrSel) >= SRC_LIMIT);
    strb.rdVec  = '0;
    strb.rdKind = RD_NONE;
    if (regAddr == ADDR_CTRL)      strb.rdKind = RD_CTRL;
    else if (regAddr == ADDR_STAT) strb.rdKind = RD_STAT;
    else if (|hit)                 strb.rdKind = RD_VEC;
    for (int i = 0; i < NUM_VEC; i++)
      if (hit[i]) strb.rdVec = VIDX_W'(i);
  end

  // R5: at most one vector register takes a write in any cycle
  a_r5_one_write: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(strb.vecWr));
endmodule

// File: rtl/vir_datapath.sv
module vir_datapath
  import vir_pkg::*;
#(
  parameter int NUM_LINES = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_EVT-1:0]   evtIn,
  input  strobe_t              strb,
  input  logic [DATA_W-1:0]    wrData,
  output logic [DATA_W-1:0]    rdData,
  output logic [NUM_LINES-1:0] irqOut,
  output logic                 cfgValid,
  output logic                 cfgErr,
  output logic [SEL_W-1:0]     cfgSrc,
  output logic [SRV_W-LINK_W-1:0] cfgServer,
  output logic [PRI_W-1:0]     cfgPrio
);
  localparam logic [PRI_W-1:0] PRI_MASKED = '1;

  logic [NUM_EVT-1:0] statusQ;
  logic [SRV_W-1:0]   srvQ  [NUM_VEC];
  logic [PRI_W-1:0]   priQ  [NUM_VEC];
  logic [SEL_W-1:0]   selQ  [NUM_VEC];
  logic [NUM_VEC-1:0] pendQ;
  logic [NUM_VEC-1:0] activeNow;
  logic [DATA_W-1:0]  vecWord [NUM_VEC];

  wire [SRV_W-1:0] wSrv = wrData[SRV_LSB +: SRV_W];
  wire [PRI_W-1:0] wPri = wrData[PRI_LSB +: PRI_W];
  wire [SEL_W-1:0] wSel = wrData[SEL_LSB +: SEL_W];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) statusQ <= '0;
    else        statusQ <= evtIn;

  genvar gv;
  generate
    for (gv = 0; gv < NUM_VEC; gv++) begin : g_vec
      logic evChange, activeNext, maskedNew;
      logic [PRI_W-1:0] priNew;
      if (gv == 0) begin : g_shared
        assign activeNow[gv] = statusQ[0] | statusQ[1];
        assign activeNext    = evtIn[0] | evtIn[1];
        assign evChange      = (statusQ[1:0] != evtIn[1:0]);
      end else begin : g_single
        assign activeNow[gv] = statusQ[gv+1];
        assign activeNext    = evtIn[gv+1];
        assign evChange      = (statusQ[gv+1] != evtIn[gv+1]);
      end
      assign priNew    = strb.vecWr[gv] ? wPri : priQ[gv];
      assign maskedNew = (priNew == PRI_MASKED);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          srvQ[gv]  <= '0;
          priQ[gv]  <= PRI_MASKED;
          selQ[gv]  <= SEL_W'(gv);
          pendQ[gv] <= 1'b0;
        end else begin
          if (strb.vecWr[gv]) begin
            srvQ[gv] <= wSrv;
            priQ[gv] <= wPri;
            selQ[gv] <= wSel;
          end
          if (evChange)             pendQ[gv] <= activeNext & ~maskedNew;
          else if (strb.vecWr[gv])  pendQ[gv] <= pendQ[gv] & ~maskedNew;
        end
      end

      always_comb begin
        vecWord[gv] = '0;
        vecWord[gv][SRV_LSB +: SRV_W] = srvQ[gv];
        vecWord[gv][PRI_LSB +: PRI_W] = priQ[gv];
        vecWord[gv][SEL_LSB +: SEL_W] = selQ[gv];
        vecWord[gv][PEND_BIT]         = pendQ[gv];
      end

      // R4: a masked vector never shows a pending flag
      a_r4_no_pend_masked: assert property (@(posedge clk) disable iff (!rst_n)
        pendQ[gv] |-> (priQ[gv] != PRI_MASKED));
      // R3: an active vector drives its selected line
      a_r3_line_high: assert property (@(posedge clk) disable iff (!rst_n)
        (activeNow[gv] && int'(selQ[gv]) < NUM_LINES) |-> irqOut[selQ[gv]]);
      // R6: a masking write leaves the pending flag clear
      a_r6_mask_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (strb.vecWr[gv] && wPri == PRI_MASKED) |=> !pendQ[gv]);
    end
  endgenerate

  always_comb begin
    irqOut = '0;
    for (int k = 0; k < NUM_LINES; k++)
      for (int v = 0; v < NUM_VEC; v++)
        if (activeNow[v] && int'(selQ[v]) == k) irqOut[k] = 1'b1;
  end

  always_comb begin
    rdData = '1;
    case (strb.rdKind)
      RD_CTRL: begin
        rdData = '0;
        rdData[CTRL_EVT0_BIT]   = statusQ[0];
        rdData[CTRL_EVT0_BIT-1] = statusQ[1];
      end
      RD_STAT: begin
        rdData = '0;
        for (int e = 2; e < NUM_EVT; e++)
          rdData[STAT_EVT2_BIT-(e-2)] = statusQ[e];
      end
      RD_VEC:  rdData = vecWord[strb.rdVec];
      default: rdData = '1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfgValid  <= 1'b0;
      cfgErr    <= 1'b0;
      cfgSrc    <= '0;
      cfgServer <= '0;
      cfgPrio   <= '0;
    end else begin
      cfgValid <= 1'b0;
      cfgErr   <= 1'b0;
      if (|strb.vecWr) begin
        if (strb.srcBad) cfgErr <= 1'b1;
        else begin
          cfgValid  <= 1'b1;
          cfgSrc    <= wSel;
          cfgServer <= wSrv[SRV_W-1:LINK_W];
          cfgPrio   <= wPri;
        end
      end
    end
  end

  // R2: status bits follow event inputs one edge later
  a_r2_status_follow: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (statusQ == $past(evtIn)));
  // R7: update and error pulses never coincide
  a_r7_pulse_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfgValid && cfgErr));
  // R8: an out-of-range select yields the error pulse
  a_r8_bad_sel: assert property (@(posedge clk) disable iff (!rst_n)
    ((|strb.vecWr) && strb.srcBad) |=> (cfgErr && !cfgValid));
endmodule

// File: rtl/vir_top.sv
module vir_top
  import vir_pkg::*;
#(
  parameter int NUM_LINES = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [5:0]           evtIn,
  input  logic                 regWrEn,
  input  logic [5:0]           regAddr,
  input  logic [63:0]          regWrData,
  output logic [63:0]          regRdData,
  output logic [NUM_LINES-1:0] irqOut,
  output logic                 cfgValid,
  output logic                 cfgErr,
  output logic [2:0]           cfgSrc,
  output logic [13:0]          cfgServer,
  output logic [7:0]           cfgPrio
);
  strobe_t strb;

  vir_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .regWrEn (regWrEn),
    .regAddr (regAddr),
    .wrSel   (regWrData[SEL_LSB +: SEL_W]),
    .strb    (strb)
  );

  vir_datapath #(.NUM_LINES(NUM_LINES)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .evtIn     (evtIn),
    .strb      (strb),
    .wrData    (regWrData),
    .rdData    (regRdData),
    .irqOut    (irqOut),
    .cfgValid  (cfgValid),
    .cfgErr    (cfgErr),
    .cfgSrc    (cfgSrc),
    .cfgServer (cfgServer),
    .cfgPrio   (cfgPrio)
  );
endmodule

// File: tb/sim_vir_top.sv
module sim_vir_top;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  evtIn = '0;
  logic        regWrEn = 1'b0;
  logic [5:0]  regAddr = '0;
  logic [63:0] regWrData = '0;
  logic [63:0] regRdData;
  logic [7:0]  irqOut;
  logic        cfgValid, cfgErr;
  logic [2:0]  cfgSrc;
  logic [13:0] cfgServer;
  logic [7:0]  cfgPrio;

  int nChk = 0;
  int nBad = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  vir_top u0 (.*);

  function automatic logic [63:0] vw(input logic [15:0] s, input logic [7:0] p,
                                     input logic [2:0] sel, input logic pend);
    vw = {8'h00, s, p, sel, 4'h0, pend, 24'h0};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rd(input logic [5:0] a, output logic [63:0] v);
    regAddr = a;
    #1;
    v = regRdData;
  endtask

  task automatic wr(input logic [5:0] a, input logic [63:0] d);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    tick();
    regWrEn = 1'b0;
  endtask

  task automatic setEvt(input logic [5:0] e);
    evtIn = e;
    tick();
  endtask

  task automatic t_reset();
    logic [63:0] v;
    rd(6'h10, v); chk("R1 vec0", v, vw(16'h0, 8'hFF, 3'd0, 1'b0));
    rd(6'h16, v); chk("R1 vec1", v, vw(16'h0, 8'hFF, 3'd1, 1'b0));
    rd(6'h19, v); chk("R1 vec4", v, vw(16'h0, 8'hFF, 3'd4, 1'b0));
    rd(6'h0E, v); chk("R1 ctrl", v, 64'h0);
    rd(6'h15, v); chk("R1 stat", v, 64'h0);
    chk("R1 lines", 64'(irqOut), 64'h0);
  endtask

  task automatic t_shared();
    logic [63:0] v;
    wr(6'h10, vw(16'h0014, 8'h05, 3'd3, 1'b0));
    chk("R7 valid", 64'(cfgValid), 64'h1);
    chk("R7 server", 64'(cfgServer), 64'h5);
    chk("R7 prio", 64'(cfgPrio), 64'h5);
    chk("R7 src", 64'(cfgSrc), 64'h3);
    tick();
    chk("R7 one pulse", 64'(cfgValid), 64'h0);
    rd(6'h10, v); chk("R5 write fields", v, vw(16'h0014, 8'h05, 3'd3, 1'b0));
    setEvt(6'b000001);
    rd(6'h0E, v); chk("R2 evt0 bit47", v, 64'h0000_8000_0000_0000);
    chk("R3 line3 up", 64'(irqOut), 64'h08);
    rd(6'h10, v); chk("R4 pending set", v, vw(16'h0014, 8'h05, 3'd3, 1'b1));
    setEvt(6'b000011);
    rd(6'h0E, v); chk("R2 evt0+1", v, 64'h0000_C000_0000_0000);
    setEvt(6'b000010);
    chk("R3 shared holds", 64'(irqOut), 64'h08);
    rd(6'h10, v); chk("R4 shared pend", v, vw(16'h0014, 8'h05, 3'd3, 1'b1));
    setEvt(6'b000000);
    chk("R3 shared drops", 64'(irqOut), 64'h00);
    rd(6'h10, v); chk("R4 pend clear", v, vw(16'h0014, 8'h05, 3'd3, 1'b0));
  endtask

  task automatic t_keep_pend();
    logic [63:0] v;
    wr(6'h16, vw(16'h0100, 8'h02, 3'd1, 1'b0));
    chk("R7 server shift", 64'(cfgServer), 64'h40);
    setEvt(6'b000100);
    rd(6'h15, v); chk("R2 evt2 bit36", v, 64'h0000_0010_0000_0000);
    chk("R3 line1", 64'(irqOut), 64'h02);
    wr(6'h16, vw(16'h0200, 8'h07, 3'd1, 1'b0) | 64'hFF00_0000_00FF_FFFF);
    rd(6'h16, v); chk("R5 keep pend", v, vw(16'h0200, 8'h07, 3'd1, 1'b1));
    wr(6'h16, vw(16'h0200, 8'hFF, 3'd1, 1'b0));
    rd(6'h16, v); chk("R6 mask clears", v, vw(16'h0200, 8'hFF, 3'd1, 1'b0));
    chk("R3 masked line", 64'(irqOut), 64'h02);
    setEvt(6'b000000);
  endtask

  task automatic t_bad_sel();
    logic [63:0] v;
    wr(6'h17, vw(16'h0040, 8'h01, 3'd7, 1'b0));
    chk("R8 err", 64'(cfgErr), 64'h1);
    chk("R8 no valid", 64'(cfgValid), 64'h0);
    rd(6'h17, v); chk("R8 stored", v, vw(16'h0040, 8'h01, 3'd7, 1'b0));
    setEvt(6'b001000);
    chk("R8 line7", 64'(irqOut), 64'h80);
    rd(6'h15, v); chk("R2 evt3 bit35", v, 64'h0000_0008_0000_0000);
    setEvt(6'b000000);
  endtask

  task automatic t_misc();
    logic [63:0] v;
    setEvt(6'b110000);
    rd(6'h15, v); chk("R2 evt4+5", v, 64'h0000_0006_0000_0000);
    chk("R3 lines3,4", 64'(irqOut), 64'h18);
    rd(6'h19, v); chk("R4 masked no pend", v, vw(16'h0, 8'hFF, 3'd4, 1'b0));
    wr(6'h15, 64'h0);
    rd(6'h15, v); chk("R9 stat write ignored", v, 64'h0000_0006_0000_0000);
    wr(6'h0E, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(6'h0E, v); chk("R9 ctrl write ignored", v, 64'h0);
    wr(6'h3F, 64'h0);
    chk("R9 no cfg pulse", 64'({cfgValid, cfgErr}), 64'h0);
    rd(6'h3F, v); chk("R9 unmapped", v, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(6'h11, v); chk("R9 hole", v, 64'hFFFF_FFFF_FFFF_FFFF);
    setEvt(6'b000000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_shared();
    t_keep_pend();
    t_bad_sel();
    t_misc();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        nChk++; nBad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end
endmodule